// File: doc/BRIEF.md
# Watchdog Timer with Self-Service Drive

This block watches a heartbeat signal from a processor. Every transition on the monitored signal, rising or falling, restarts an internal timeout counter. If the counter runs a full timeout period without a transition, the block raises a one-cycle expiry pulse toward the reset generator and starts counting again from zero. A hold input carries the system reset back into the block. While it is high the counter stays at zero and cannot expire. Counting resumes on the first clock after it drops.

The block also derives a service waveform from its own counter. The waveform is low while the count is below seven eighths of the period and high from there on. A drive-enable input models whether something external drives the watchdog pin. When it is low, the pin takes the service waveform, so its rising edge restarts the counter well before expiry and an unconnected pin never times out. A mode input can also select the service waveform directly as the monitored signal, whatever the pin does. The external input passes through a two-flop synchronizer before edge detection.

Top module: `wdog_selfserve`

## Requirements
- R1: While `rst_n` is low at a clock edge, `expire_o` and `svc_drive_o` are both low after that edge.
- R2: With the monitored signal static, `expire_o` goes high in the cycle after the TIMEOUT-th clock edge following the last counter clear or reset release.
- R3: `expire_o` is high for exactly one cycle, and the counter restarts, so with a static input the next pulse follows TIMEOUT cycles later.
- R4: In pin mode (`mon_sel_i`=0) with `wdi_drv_en_i`=1, each rising or falling edge of `wdi_i` restarts the counter. The edge takes effect three clock edges after the input changes, so toggling faster than the timeout produces no expiry.
- R5: While `sys_hold_i` is high the counter is held at zero: no expiry occurs and `svc_drive_o` stays low. After release the first pulse follows R2.
- R6: `svc_drive_o` is high exactly when the count is at least TIMEOUT - TIMEOUT/8. It first rises in the cycle after the (TIMEOUT - TIMEOUT/8)-th edge following a clear.
- R7: With `wdi_drv_en_i`=0 the pin follows `svc_drive_o`, and the block never expires.
- R8: With `mon_sel_i`=1 the service waveform is monitored and `wdi_i` has no effect. The block never expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_hold_i | input | 1 | System reset asserted; holds the counter at zero |
| wdi_i | input | 1 | External watchdog heartbeat (asynchronous) |
| wdi_drv_en_i | input | 1 | 1: pin driven by `wdi_i`; 0: pin follows the service waveform |
| mon_sel_i | input | 1 | 0: monitor the pin; 1: monitor the service waveform |
| expire_o | output | 1 | One-cycle timeout pulse |
| svc_drive_o | output | 1 | Internal service waveform, high in the last eighth of the period |

## Verification
The hardest situation to reach is the self-service loop. In that loop the block's own waveform travels through the synchronizer and clears the counter a few cycles after crossing seven eighths. This must happen period after period without any drift toward expiry. The bench reaches it by releasing the pin (`wdi_drv_en_i`=0) and then by selecting internal mode while `wdi_i` toggles. It runs many periods in each case with a small TIMEOUT, and a cycle-accurate model compares both outputs on every clock.

// File: rtl/wdog_pkg.sv
// Shared types for the watchdog block.
// Assumes: a single clock domain apart from the external heartbeat input.
package wdog_pkg;
    typedef enum logic {
        MON_PIN      = 1'b0,
        MON_INTERNAL = 1'b1
    } mon_src_e;
endpackage

// File: rtl/wdog_sync.sv
// Multi-stage synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; reset clears the chain to 0.
module wdog_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Capture the input into the first stage.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Shift the value one stage further along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/wdog_edge.sv
// Detects either edge of a synchronized level.
// Assumes: input is already synchronous to clk; output is combinational.
module wdog_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic toggle_o
);
    logic level_q;

    // Remember the previous level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign toggle_o = level_i ^ level_q;
endmodule

// File: rtl/wdog_count.sv
// Timeout counter with expiry pulse and service waveform.
// Assumes: TIMEOUT >= 32 so the self-service clear lands before the last count.
module wdog_count #(
    parameter int TIMEOUT = 80_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic clear_i,
    output logic expire_o,
    output logic svc_o
);
    localparam int CW       = $clog2(TIMEOUT);
    localparam int HI_START = TIMEOUT - TIMEOUT / 8;
    localparam logic [CW-1:0] LAST   = CW'(TIMEOUT - 1);
    localparam logic [CW-1:0] HI_CNT = CW'(HI_START);

    logic [CW-1:0] cnt;
    logic          exp_q;

    // Advance, clear or wrap the count, and flag the wrap as expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            cnt   <= '0;
            exp_q <= 1'b0;
        end else if (clear_i) begin
            cnt   <= '0;
            exp_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            exp_q <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            exp_q <= 1'b0;
        end
    end

    assign expire_o = exp_q;
    assign svc_o    = (cnt >= HI_CNT);
endmodule

// File: rtl/wdog_selfserve.sv
// Watchdog timer top: selects the monitored source, synchronizes it,
// detects edges and runs the timeout counter.
// Assumes: rst_n synchronous active-low; sys_hold_i synchronous to clk.
module wdog_selfserve #(
    parameter int TIMEOUT     = 80_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_hold_i,
    input  logic wdi_i,
    input  logic wdi_drv_en_i,
    input  logic mon_sel_i,
    output logic expire_o,
    output logic svc_drive_o
);
    import wdog_pkg::*;

    mon_src_e src;
    logic     pin_lvl;
    logic     mon_lvl;
    logic     mon_sync;
    logic     toggle;
    logic     svc;

    // Resolve the pin level and the monitored source.
    always_comb begin
        src     = mon_src_e'(mon_sel_i);
        pin_lvl = wdi_drv_en_i ? wdi_i : svc;
        mon_lvl = (src == MON_INTERNAL) ? svc : pin_lvl;
    end

    wdog_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mon_lvl),
        .dout  (mon_sync)
    );

    wdog_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (mon_sync),
        .toggle_o (toggle)
    );

    wdog_count #(.TIMEOUT(TIMEOUT)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (sys_hold_i),
        .clear_i  (toggle),
        .expire_o (expire_o),
        .svc_o    (svc)
    );

    assign svc_drive_o = svc;
endmodule

// File: rtl/wdog_selfserve_chk.sv
// Port-level assertions for wdog_selfserve, attached by bind.
module wdog_selfserve_chk (
    input logic clk,
    input logic rst_n,
    input logic sys_hold_i,
    input logic expire_o,
    input logic svc_drive_o
);
    // R1: reset clears both outputs.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!expire_o && !svc_drive_o));

    // R3: expiry never lasts two cycles.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

    // R5: hold suppresses expiry.
    a_r5_hold_no_expire: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hold_i |=> !expire_o);

    // R5: hold forces the service waveform low.
    a_r5_hold_svc_low: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hold_i |=> !svc_drive_o);

    // R6: expiry follows a cycle spent in the high part of the waveform.
    a_r6_svc_before_expire: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(svc_drive_o));
endmodule

bind wdog_selfserve wdog_selfserve_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_hold_i  (sys_hold_i),
    .expire_o    (expire_o),
    .svc_drive_o (svc_drive_o)
);

// File: tb/sim_wdog_selfserve.sv
`timescale 1ns/1ps
module sim_wdog_selfserve;
    localparam int T  = 64;
    localparam int HI = T - T / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0, hold = 1'b0, wdi = 1'b0, drv_en = 1'b1, msel = 1'b0;
    logic expire, svc;
    int   checks = 0, errors = 0, cycles = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    wdog_selfserve #(.TIMEOUT(T)) u0 (
        .clk(clk), .rst_n(rst_n), .sys_hold_i(hold), .wdi_i(wdi),
        .wdi_drv_en_i(drv_en), .mon_sel_i(msel),
        .expire_o(expire), .svc_drive_o(svc)
    );

    // Behavioural reference: delay queue for synchronizer, integer count.
    int m_cnt = 0;
    bit m_exp = 0;
    bit pipe[$] = '{0, 0, 0};

    always @(posedge clk) begin
        bit m_svc, mon, tog;
        m_svc = (m_cnt >= HI);
        mon   = msel ? m_svc : (drv_en ? wdi : m_svc);
        tog   = pipe[1] ^ pipe[2];
        pipe.push_front(mon);
        void'(pipe.pop_back());
        if (!rst_n) begin
            pipe = '{0, 0, 0};
            m_cnt = 0; m_exp = 0;
        end else if (hold || tog) begin
            m_cnt = 0; m_exp = 0;
        end else if (m_cnt == T - 1) begin
            m_cnt = 0; m_exp = 1;
        end else begin
            m_cnt++; m_exp = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare the model with the design on every cycle.
    always @(negedge clk) begin
        cycles++;
        chk({phase, " model expire"}, int'(expire), int'(m_exp));
        chk({phase, " model svc"}, int'(svc), int'(m_exp ? 0 : (m_cnt >= HI)));
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Count pulses over n cycles.
    task automatic run_count(int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (expire) pulses++;
        end
    endtask

    initial begin
        int p, first, second, svc_hi_at, wide;
        repeat (5) @(negedge clk);
        chk("R1 expire in reset", int'(expire), 0);
        chk("R1 svc in reset", int'(svc), 0);

        // R2/R3/R6: static driven input after reset release.
        phase = "R2";
        rst_n = 1'b1;
        first = -1; second = -1; svc_hi_at = -1; wide = 0;
        for (int i = 1; i <= 2 * T + 2; i++) begin
            @(negedge clk);
            if (svc && svc_hi_at < 0) svc_hi_at = i;
            if (expire && first < 0) first = i;
            else if (expire && first > 0 && i == first + 1) wide = 1;
            else if (expire && second < 0) second = i;
        end
        chk("R2 first expiry cycle", first, T);
        chk("R3 pulse width one", wide, 0);
        chk("R3 second expiry cycle", second, 2 * T);
        chk("R6 svc first high cycle", svc_hi_at, HI);

        // R4: toggle external input faster than timeout.
        phase = "R4";
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); wdi = ~wdi;
            run_count(T / 2, p);
            chk("R4 no expiry while toggling", p, 0);
        end

        // R5: long hold, then first pulse T cycles after release.
        phase = "R5";
        @(negedge clk); hold = 1'b1;
        run_count(3 * T, p);
        chk("R5 no expiry in hold", p, 0);
        chk("R5 svc low in hold", int'(svc), 0);
        hold = 1'b0;
        first = -1;
        for (int i = 1; i <= T + 2; i++) begin
            @(negedge clk);
            if (expire && first < 0) first = i;
        end
        chk("R5 expiry after release", first, T);

        // R7: pin undriven, self-service.
        phase = "R7";
        drv_en = 1'b0;
        run_count(12 * T, p);
        chk("R7 no expiry undriven", p, 0);

        // R8: internal mode, external toggles ignored.
        phase = "R8";
        drv_en = 1'b1; msel = 1'b1;
        for (int k = 0; k < 8 * T; k++) begin
            @(negedge clk);
            if (k % 5 == 0) wdi = ~wdi;
            if (expire) p++;
        end
        chk("R8 no expiry internal mode", p, 0);

        // R1: reset mid-run.
        phase = "R1";
        msel = 1'b0; wdi = 1'b0;
        repeat (T - 4) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 expire after mid reset", int'(expire), 0);
        chk("R1 svc after mid reset", int'(svc), 0);
        rst_n = 1'b1;
        repeat (T + 4) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule